// File: doc/BRIEF.md
# Prescaled Compare-Match Event Timer

This block is a 16-bit tick timer for a host that needs either a steady periodic interrupt or a single timed wake-up. It counts pulses of a slow reference clock through a power-of-two prescaler. A pulse input (`ref_tick`) marks each reference edge and is already synchronous to `clk`. The counter is compared against two compare registers. A match raises a sticky event flag, and either flag can be routed to a level interrupt.

The host arms an interval in a fixed order. It loads a delta into the second compare register, writes zero to the counter, then writes the control word with the enable bit set. When the interrupt arrives, one control-word write with the enable bit low and both flag bits high stops the counter and acknowledges both events at once. For a periodic tick, the host then rewrites the counter and sets the enable bit again.

The register port is a plain address / write-data / write-strobe interface with registered read data. Address map: 0 = control, 1 = counter, 2 = first compare (CMPA), 3 = second compare (CMPB).

Top module: `tmr_event_timer`

## Requirements
- R1: After reset, all four registers read 0x0000 and `irq` is low.
- R2: While enabled, the counter advances by one for every 2^s `ref_tick` pulses, where s is control bits 3:0. Any s above 8 behaves as 8, so s=4 gives one step per 16 pulses.
- R3: With control bit 15 (enable) low, `ref_tick` pulses leave the counter unchanged.
- R4: A write to the counter loads the written value and restarts the prescaler from zero, so a full 2^s pulses are needed before the next step.
- R5: When the counter steps onto the value of CMPA, control bit 5 sets. When it steps onto CMPB, control bit 6 sets. Each flag is set on the same clock edge as the step and stays set until it is cleared.
- R6: Writing a 1 to control bit 5 or 6 clears that flag, and writing a 0 leaves it unchanged. If a match occurs in the same cycle as the clear, the flag stays set.
- R7: `irq` is high exactly when (bit 6 is set and control bits 9:8 equal 3) or (bit 5 is set and control bits 11:10 equal 3). It changes on the same edge as the flags.
- R8: Control bit 7 is a read-only status bit. It reads 1 after any write to the control register and is cleared only by reset.
- R9: `rdata` presents, one cycle after `addr` is applied, the register at that address. Control reads back as {bit15 enable, bits 14:12 zero, 11:10 CMPA mode, 9:8 CMPB mode, 7 status, 6 CMPB flag, 5 CMPA flag, 4 zero, 3:0 scale}.
- R10: The counter wraps from 0xFFFF to 0x0000, and stepping onto a compare value of 0 sets that flag.
- R11: A single control write with bit 15 low and bits 5 and 6 high stops counting and clears both flags. `irq` drops on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock edge |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
Flag, counter and `irq` effects of a pulse or write appear on the clock edge that samples them. Read data for an address appears one edge after the address is applied. The bench drives each input set at a falling edge and advances its reference model by one edge. It then compares at the next falling edge, so every check looks at exactly the edge its result is due on. Directed sequences pin known counts at prescaler boundaries, wrap, write-one-clear races and the combined stop-and-clear write. A seeded random phase then compares every readback and `irq` against the model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 2'd2;

  localparam int NUM_CH     = 2;
  localparam int BIT_EN     = 15;
  localparam int BIT_STAT   = 7;
  localparam int BIT_FLAG0  = 5;
  localparam int SCALE_LO   = 0;
  localparam logic [1:0] MODE_IRQ = 2'd3;

  // channel 0 = CMPA (mode at 11:10), channel 1 = CMPB (mode at 9:8)
  function automatic int mode_pos(input int ch);
    return 10 - 2 * ch;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SCALE_W   = 4,
  parameter int MAX_SCALE = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               ref_tick,
  input  logic               restart,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  localparam int PRE_W = (MAX_SCALE < 1) ? 1 : MAX_SCALE;

  logic [SCALE_W-1:0] eff_scale;
  logic [PRE_W:0]     span;
  logic [PRE_W:0]     limit;
  logic [PRE_W:0]     pcnt_q;
  logic               at_limit;

  always_comb begin
    eff_scale = (scale > SCALE_W'(MAX_SCALE)) ? SCALE_W'(MAX_SCALE) : scale;
    span      = (PRE_W+1)'(1) << eff_scale;
    limit     = span - (PRE_W+1)'(1);
    at_limit  = (pcnt_q >= limit);
    tick      = run && ref_tick && !restart && at_limit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
    end else if (restart) begin
      pcnt_q <= '0;
    end else if (run && ref_tick) begin
      pcnt_q <= at_limit ? '0 : pcnt_q + (PRE_W+1)'(1);
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next
);
  assign cnt_next = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step) begin
      cnt_q <= cnt_next;
    end
  end
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wval,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cmp_q,
  output logic             flag_q,
  output logic             flag_d
);
  logic hit;

  always_comb begin
    hit    = step && (cnt_next == cmp_q);
    flag_d = hit || (flag_q && !flag_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (cmp_wr) cmp_q <= cmp_wval;
    end
  end
endmodule

// File: rtl/tmr_event_timer.sv
module tmr_event_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SCALE_W   = 4,
  parameter int MAX_SCALE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic                           ctrl_wr, cnt_wr;
  logic                           en_q, stat_q;
  logic [SCALE_W-1:0]             scale_q;
  logic [NUM_CH-1:0][1:0]         mode_q, mode_d;
  logic [NUM_CH-1:0]              flag_q, flag_d, flag_clr, cmp_wr, irq_sel;
  logic [NUM_CH-1:0][CNT_W-1:0]   cmp_val;
  logic [CNT_W-1:0]               cnt_q, cnt_next;
  logic                           tick;
  logic [DATA_W-1:0]              ctrl_word, rd_mux;
  logic                           irq_q;
  logic [DATA_W-1:0]              rdata_q;

  assign ctrl_wr = wr_en && (addr == ADDR_CTRL);
  assign cnt_wr  = wr_en && (addr == ADDR_CNT);

  tmr_prescaler #(.SCALE_W(SCALE_W), .MAX_SCALE(MAX_SCALE)) pre_i (
    .clk(clk), .rst(rst), .run(en_q), .ref_tick(ref_tick),
    .restart(cnt_wr), .scale(scale_q), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .load(cnt_wr), .load_val(wdata[CNT_W-1:0]),
    .step(tick), .cnt_q(cnt_q), .cnt_next(cnt_next)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int MP = mode_pos(ch);
    assign cmp_wr[ch]   = wr_en && (addr == ADDR_CMPA + ADDR_W'(ch));
    assign flag_clr[ch] = ctrl_wr && wdata[BIT_FLAG0 + ch];
    assign mode_d[ch]   = ctrl_wr ? wdata[MP+1:MP] : mode_q[ch];
    assign irq_sel[ch]  = (mode_d[ch] == MODE_IRQ);

    tmr_cmp_chan #(.CNT_W(CNT_W)) chan_i (
      .clk(clk), .rst(rst), .cmp_wr(cmp_wr[ch]), .cmp_wval(wdata[CNT_W-1:0]),
      .step(tick), .cnt_next(cnt_next), .flag_clr(flag_clr[ch]),
      .cmp_q(cmp_val[ch]), .flag_q(flag_q[ch]), .flag_d(flag_d[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      stat_q  <= 1'b0;
      scale_q <= '0;
      mode_q  <= '0;
    end else begin
      mode_q <= mode_d;
      if (ctrl_wr) begin
        en_q    <= wdata[BIT_EN];
        scale_q <= wdata[SCALE_LO +: SCALE_W];
        stat_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_EN]   = en_q;
    ctrl_word[BIT_STAT] = stat_q;
    ctrl_word[SCALE_LO +: SCALE_W] = scale_q;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      ctrl_word[BIT_FLAG0 + ch] = flag_q[ch];
      ctrl_word[mode_pos(ch) +: 2] = mode_q[ch];
    end
    case (addr)
      ADDR_CTRL: rd_mux = ctrl_word;
      ADDR_CNT:  rd_mux = DATA_W'(cnt_q);
      ADDR_CMPA: rd_mux = DATA_W'(cmp_val[0]);
      default:   rd_mux = DATA_W'(cmp_val[1]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q   <= |(flag_d & irq_sel);
      rdata_q <= rd_mux;
    end
  end

  assign irq   = irq_q;
  assign rdata = rdata_q;
endmodule

module tmr_event_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [1:0]               addr,
  input logic [15:0]              wdata,
  input logic                     en_q,
  input logic                     stat_q,
  input logic [CNT_W-1:0]         cnt_q,
  input logic [1:0][CNT_W-1:0]    cmp_val,
  input logic [1:0]               flag_q,
  input logic [1:0][1:0]          mode_q,
  input logic                     irq
);
  logic cnt_w, ctrl_w;
  assign cnt_w  = wr_en && (addr == 2'd1);
  assign ctrl_w = wr_en && (addr == 2'd0);

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !cnt_w) |=> $stable(cnt_q));

  assert_step_by_one_R10: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cnt_q) && !$past(cnt_w)) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  assert_cmpb_rise_on_match_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[1]) |-> (cnt_q == $past(cmp_val[1])));

  assert_cmpa_rise_on_match_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[0]) |-> (cnt_q == $past(cmp_val[0])));

  assert_cmpb_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_q[1] && !(ctrl_w && wdata[6])) |=> flag_q[1]);

  assert_cmpa_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_q[0] && !(ctrl_w && wdata[5])) |=> flag_q[0]);

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    irq == ((flag_q[1] && mode_q[1] == 2'd3) || (flag_q[0] && mode_q[0] == 2'd3)));

  assert_status_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    stat_q |=> stat_q);
endmodule

bind tmr_event_timer tmr_event_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .en_q(en_q), .stat_q(stat_q), .cnt_q(cnt_q), .cmp_val(cmp_val),
  .flag_q(flag_q), .mode_q(mode_q), .irq(irq)
);

// File: tb/tmr_event_timer_tb_top.sv
`timescale 1ns/1ps
module tmr_event_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        irq;

  always #2 clk = ~clk;

  tmr_event_timer dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [15:0] m_cnt = 0, m_cmpa = 0, m_cmpb = 0;
  logic        m_en = 0, m_fa = 0, m_fb = 0, m_stat = 0;
  logic [3:0]  m_scale = 0;
  logic [1:0]  m_mda = 0, m_mdb = 0;
  int          m_pre = 0;
  logic [15:0] e_rd = 0;
  logic        e_irq = 0;

  function automatic logic [15:0] ctrl_model();
    return {m_en, 3'b000, m_mda, m_mdb, m_stat, m_fb, m_fa, 1'b0, m_scale};
  endfunction

  function automatic logic [15:0] read_model(input logic [1:0] a);
    case (a)
      2'd0: return ctrl_model();
      2'd1: return m_cnt;
      2'd2: return m_cmpa;
      default: return m_cmpb;
    endcase
  endfunction

  function automatic int divisor(input logic [3:0] s);
    return (s > 4'd8) ? 256 : (1 << s);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at falling edge, advance model, land on next falling edge
  task automatic cyc(input bit w, input logic [1:0] a, input logic [15:0] d, input bit r);
    bit cw, cwr, tk;
    logic [15:0] nx;
    wr_en = w; addr = a; wdata = d; ref_tick = r;
    e_rd = read_model(a);
    cw  = w && (a == 2'd1);
    cwr = w && (a == 2'd0);
    tk  = m_en && r && !cw && (m_pre >= divisor(m_scale) - 1);
    if (cw) m_pre = 0;
    else if (m_en && r) m_pre = tk ? 0 : m_pre + 1;
    nx = m_cnt + 16'd1;
    m_fa = (tk && nx == m_cmpa) || (m_fa && !(cwr && d[5]));
    m_fb = (tk && nx == m_cmpb) || (m_fb && !(cwr && d[6]));
    m_cnt = cw ? d : (tk ? nx : m_cnt);
    if (cwr) begin
      m_en = d[15]; m_mda = d[11:10]; m_mdb = d[9:8]; m_scale = d[3:0]; m_stat = 1'b1;
    end
    if (w && a == 2'd2) m_cmpa = d;
    if (w && a == 2'd3) m_cmpb = d;
    e_irq = (m_fb && m_mdb == 2'd3) || (m_fa && m_mda == 2'd3);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; ref_tick = 1'b0;
  endtask

  task automatic wrr(input logic [1:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 16'h0, 1'b1);
  endtask

  task automatic rd(input logic [1:0] a);
    cyc(1'b0, a, 16'h0, 1'b0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a));
      chk("R1 reset readback", rdata, 16'h0000);
    end
    chk("R1 reset irq", {15'b0, irq}, 16'h0);

    // R2/R5/R7 one interval at scale 4, CMPB=15
    wrr(2'd3, 16'd15);
    wrr(2'd1, 16'd0);
    wrr(2'd0, 16'h8304);
    pulses(239);
    rd(2'd1); chk("R2 count after 239 pulses", rdata, 16'd14);
    chk("R7 irq before match", {15'b0, irq}, 16'h0);
    pulses(1);
    chk("R7 irq on match", {15'b0, irq}, 16'h1);
    rd(2'd1); chk("R2 count after 240 pulses", rdata, 16'd15);
    rd(2'd0); chk("R5 CMPB flag set", rdata & 16'h0040, 16'h0040);
    chk("R8 status after write", rdata & 16'h0080, 16'h0080);
    pulses(16);
    rd(2'd0); chk("R5 CMPB flag sticky", rdata & 16'h0040, 16'h0040);

    // R11 stop and acknowledge in one write, R3 hold
    wrr(2'd0, 16'h0364);
    chk("R11 irq drops", {15'b0, irq}, 16'h0);
    pulses(50);
    rd(2'd1); chk("R3 counter held", rdata, 16'd16);
    rd(2'd0); chk("R11 flags cleared", rdata & 16'h0060, 16'h0000);

    // R6 write zero keeps, write one clears
    wrr(2'd2, 16'd18);
    wrr(2'd0, 16'h8C00);
    pulses(2);
    chk("R7 irq from CMPA", {15'b0, irq}, 16'h1);
    wrr(2'd0, 16'h0C00);
    rd(2'd0); chk("R6 zero write keeps flag", rdata & 16'h0020, 16'h0020);
    chk("R6 irq kept", {15'b0, irq}, 16'h1);
    wrr(2'd0, 16'h0020);
    rd(2'd0); chk("R6 one write clears flag", rdata & 16'h0020, 16'h0000);
    chk("R6 irq cleared", {15'b0, irq}, 16'h0);

    // R10 wrap onto compare value zero
    wrr(2'd2, 16'd0);
    wrr(2'd1, 16'hFFFF);
    wrr(2'd0, 16'h8000);
    pulses(1);
    rd(2'd1); chk("R10 wrap to zero", rdata, 16'h0000);
    rd(2'd0); chk("R10 match at zero", rdata & 16'h0020, 16'h0020);

    // R4 counter write restarts the prescaler (scale 2)
    wrr(2'd0, 16'h8022);
    wrr(2'd1, 16'd5);
    pulses(3);
    wrr(2'd1, 16'd5);
    pulses(3);
    rd(2'd1); chk("R4 no step before full span", rdata, 16'd5);
    pulses(1);
    rd(2'd1); chk("R4 step after full span", rdata, 16'd6);

    // R2 scale above 8 acts as 8
    wrr(2'd1, 16'd0);
    wrr(2'd0, 16'h800F);
    pulses(255);
    rd(2'd1); chk("R2 clamp no step at 255", rdata, 16'd0);
    pulses(1);
    rd(2'd1); chk("R2 clamp step at 256", rdata, 16'd1);

    // R6 match in the clearing cycle wins
    wrr(2'd0, 16'h8000);
    wrr(2'd2, 16'd3);
    pulses(1);
    cyc(1'b1, 2'd0, 16'h8020, 1'b1);
    rd(2'd0); chk("R6 set wins over clear", rdata & 16'h0020, 16'h0020);

    // R8 status cannot be written low
    wrr(2'd0, 16'h0000);
    rd(2'd0); chk("R8 status stays", rdata & 16'h0080, 16'h0080);

    // R9 compare readback
    wrr(2'd2, 16'hA5A5);
    rd(2'd2); chk("R9 CMPA readback", rdata, 16'hA5A5);
    wrr(2'd3, 16'h5A5A);
    rd(2'd3); chk("R9 CMPB readback", rdata, 16'h5A5A);

    // random phase against the model (R2 R5 R6 R7 R9)
    for (int n = 0; n < 4000; n++) begin
      bit w, r;
      logic [1:0] a;
      logic [15:0] d;
      w = ($urandom % 5) == 0;
      r = ($urandom % 2) == 0;
      a = 2'($urandom % 4);
      case (a)
        2'd0: d = {($urandom % 5) != 0, 3'b0, 2'($urandom), 2'($urandom),
                   1'b0, 2'($urandom), 1'b0, 4'($urandom % 4)};
        2'd1: d = 16'($urandom % 30);
        default: d = 16'($urandom % 40);
      endcase
      cyc(w, a, d, r);
      chk("R9 random readback", rdata, e_rd);
      chk("R7 random irq", {15'b0, irq}, {15'b0, e_irq});
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule